// File: doc/BRIEF.md
# Backpressured Two-Input Dataflow Node

This block is one node of a dataflow graph built directly in hardware. It owns the storage for its two incoming arcs: each arc is a small synchronous FIFO whose occupancy counter yields full, almost-full, empty and almost-empty flags. Combinational predictors turn those flags, together with this cycle's read and write, into the full and empty state each arc will have after the next rising edge. The upstream producers see the predicted full of the arc they feed. The node's own firing controller sees the predicted empty of both arcs.

A two-state controller (waiting, firing) moves into its firing state only when neither input arc will be empty and the downstream arc will not be full. While it fires, it pops one token from each input arc and writes one result token downstream. The result comes from a parameter-selected arithmetic function of the two head tokens. Because every status signal is a prediction rather than a registered copy, a depth of two entries per arc is enough for one token per clock.

Top module: `df_node`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_wr` is 0 and both `a_full` and `b_full` are 0; the controller starts in its waiting state.
- R2: `out_wr` is 1 in a cycle only if, in the previous cycle, neither input arc was predicted empty and `out_full` was 0; a token on only one arc never produces an output.
- R3: An arc never holds more than DEPTH tokens, and tokens held back by a missing partner or a stall are not lost: they are emitted later in arrival order.
- R4: `a_full` (and likewise `b_full`) equals (not read and full) or (not read and write and almost-full). With the node idle, the write that fills the last free slot raises it in that same cycle, and it is then 1 exactly when the arc will hold DEPTH tokens after the next edge.
- R5: The i-th output token is the configured operation applied to the i-th token of arc A and the i-th token of arc B. With the default operation this is (a + b) modulo 2^W.
- R6: If `out_full` is 1 in a cycle, `out_wr` is 0 in the next cycle; firing resumes once it drops.
- R7: With DEPTH = 2, both producers writing whenever their full indication allows, and no stall, the node emits one token on every consecutive cycle.
- R8: When both tokens of a pair are written into empty arcs in cycle k and the downstream arc has room, `out_wr` is 1 in cycle k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Write a token into arc A this cycle |
| a_data | input | W | Token value for arc A |
| a_full | output | 1 | Arc A will be full after the next edge |
| b_wr | input | 1 | Write a token into arc B this cycle |
| b_data | input | W | Token value for arc B |
| b_full | output | 1 | Arc B will be full after the next edge |
| out_wr | output | 1 | Result token written downstream this cycle |
| out_data | output | W | Result token value |
| out_full | input | 1 | Downstream arc will be full after the next edge |

## Verification
On every cycle, the assertions check four things. The node writes only while both arcs hold a token. It never writes the cycle after a downstream stall. Neither arc exceeds its depth. Each predicted full matches the arc occupancy that follows one edge later. Only the bench scenarios can show that values pair up in order through partner starvation and stalls, that a pair into empty arcs comes out exactly one cycle later, and that an unstalled stream runs at one token per clock with two-entry arcs.

// File: rtl/df_pkg.sv
package df_pkg;
  typedef enum logic {
    FIRE_WAIT = 1'b0,
    FIRE_PROC = 1'b1
  } fire_st_t;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2
  } op_kind_t;
endpackage

// File: rtl/df_arc_fifo.sv
module df_arc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          afull,
  output logic          empty,
  output logic          aempty,
  output logic [CW-1:0] level
);
  localparam logic [CW-1:0] LV_TOP  = CW'(DEPTH);
  localparam logic [CW-1:0] LV_NEAR = CW'(DEPTH - 1);
  localparam logic [AW-1:0] PTR_END = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  // a write into a full arc is legal only when the same edge frees a slot
  assign wr_ok = wr && (!full || rd);
  assign rd_ok = rd && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == PTR_END) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == PTR_END) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdata  = mem[rptr];
  assign full   = (level == LV_TOP);
  assign afull  = (level == LV_NEAR);
  assign empty  = (level == '0);
  assign aempty = (level == CW'(1));
endmodule

// File: rtl/df_predict.sv
module df_predict (
  input  logic wr,
  input  logic rd,
  input  logic full,
  input  logic afull,
  input  logic empty,
  input  logic aempty,
  output logic nxt_full,
  output logic nxt_empty
);
  // state of the arc after the coming edge, from flags plus this cycle's traffic
  assign nxt_full  = (!rd && full)  || (!rd && wr && afull);
  assign nxt_empty = (!wr && empty) || (!wr && rd && aempty);
endmodule

// File: rtl/df_fire_ctrl.sv
module df_fire_ctrl #(
  parameter int N_IN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] in_nxt_empty,
  input  logic            out_nxt_full,
  output logic            fire
);
  import df_pkg::*;

  fire_st_t st, st_nxt;

  always_comb begin
    if (!(|in_nxt_empty) && !out_nxt_full) st_nxt = FIRE_PROC;
    else                                   st_nxt = FIRE_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= FIRE_WAIT;
    else     st <= st_nxt;
  end

  assign fire = (st == FIRE_PROC);
endmodule

// File: rtl/df_node.sv
module df_node #(
  parameter int               W     = 16,
  parameter int               DEPTH = 2,
  parameter df_pkg::op_kind_t OP    = df_pkg::OP_ADD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_wr,
  input  logic [W-1:0] a_data,
  output logic         a_full,
  input  logic         b_wr,
  input  logic [W-1:0] b_data,
  output logic         b_full,
  output logic         out_wr,
  output logic [W-1:0] out_data,
  input  logic         out_full
);
  import df_pkg::*;

  localparam int N_IN = 2;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [N_IN-1:0] arc_wr;
  logic [W-1:0]    arc_wdata [N_IN];
  logic [W-1:0]    arc_head  [N_IN];
  logic [CW-1:0]   arc_lvl   [N_IN];
  logic [N_IN-1:0] arc_nxt_full;
  logic [N_IN-1:0] arc_nxt_empty;
  logic            fire;
  logic [CW-1:0]   a_lvl, b_lvl;
  logic [W-1:0]    op_res;

  assign arc_wr       = {b_wr, a_wr};
  assign arc_wdata[0] = a_data;
  assign arc_wdata[1] = b_data;

  for (genvar i = 0; i < N_IN; i++) begin : g_arc
    logic f, af, e, ae;

    df_arc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .wr     (arc_wr[i]),
      .wdata  (arc_wdata[i]),
      .rd     (fire),
      .rdata  (arc_head[i]),
      .full   (f),
      .afull  (af),
      .empty  (e),
      .aempty (ae),
      .level  (arc_lvl[i])
    );

    df_predict u_pred (
      .wr        (arc_wr[i]),
      .rd        (fire),
      .full      (f),
      .afull     (af),
      .empty     (e),
      .aempty    (ae),
      .nxt_full  (arc_nxt_full[i]),
      .nxt_empty (arc_nxt_empty[i])
    );
  end

  df_fire_ctrl #(.N_IN(N_IN)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .in_nxt_empty (arc_nxt_empty),
    .out_nxt_full (out_full),
    .fire         (fire)
  );

  if (OP == OP_SUB) begin : g_op_sub
    assign op_res = arc_head[0] - arc_head[1];
  end else if (OP == OP_MUL) begin : g_op_mul
    assign op_res = arc_head[0] * arc_head[1];
  end else begin : g_op_add
    assign op_res = arc_head[0] + arc_head[1];
  end

  assign a_lvl    = arc_lvl[0];
  assign b_lvl    = arc_lvl[1];
  assign a_full   = arc_nxt_full[0];
  assign b_full   = arc_nxt_full[1];
  assign out_wr   = fire;
  assign out_data = op_res;
endmodule

// File: rtl/df_node_chk.sv
module df_node_chk #(
  parameter int DEPTH = 2,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          a_full,
  input logic          b_full,
  input logic          out_wr,
  input logic          out_full,
  input logic [CW-1:0] a_lvl,
  input logic [CW-1:0] b_lvl
);
  localparam logic [CW-1:0] LV_TOP = CW'(DEPTH);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_wr);

  p_tokens_present_r2: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> (a_lvl != '0 && b_lvl != '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (a_lvl <= LV_TOP) && (b_lvl <= LV_TOP));

  p_pred_full_a_r4: assert property (@(posedge clk) disable iff (rst)
    a_full |=> (a_lvl == LV_TOP));

  p_pred_room_a_r4: assert property (@(posedge clk) disable iff (rst)
    !a_full |=> (a_lvl < LV_TOP));

  p_pred_full_b_r4: assert property (@(posedge clk) disable iff (rst)
    b_full |=> (b_lvl == LV_TOP));

  p_pred_room_b_r4: assert property (@(posedge clk) disable iff (rst)
    !b_full |=> (b_lvl < LV_TOP));

  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    out_full |=> !out_wr);
endmodule

bind df_node df_node_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_full   (a_full),
  .b_full   (b_full),
  .out_wr   (out_wr),
  .out_full (out_full),
  .a_lvl    (a_lvl),
  .b_lvl    (b_lvl)
);

// File: tb/sim_df_node.sv
`timescale 1ns/1ps
module sim_df_node;
  localparam int W     = 16;
  localparam int DEPTH = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         a_wr = 1'b0, b_wr = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic         a_full, b_full, out_wr;
  logic [W-1:0] out_data;
  logic         out_full = 1'b0;

  df_node #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_data(a_data), .a_full(a_full),
    .b_wr(b_wr), .b_data(b_data), .b_full(b_full),
    .out_wr(out_wr), .out_data(out_data), .out_full(out_full)
  );

  always #5 clk = ~clk;

  int           n_run = 0, n_fail = 0;
  int           cyc = 0;
  logic [W-1:0] qa[$], qb[$], exp_q[$];
  logic         a_en = 1'b0, b_en = 1'b0;
  int           n_out = 0;
  bit           lat_mode = 0, tp_mode = 0, r4_mode = 0;
  int           last_wr_cyc = -10, last_out_cyc = -10, a_wcnt = 0;
  logic         prev_out_full = 1'b0;
  bit           finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] got, logic [31:0] expv);
    n_run++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, expv);
    end
  endtask

  task automatic push_pair(logic [W-1:0] a, logic [W-1:0] b);
    qa.push_back(a);
    qb.push_back(b);
    exp_q.push_back(a + b);
  endtask

  task automatic drain(string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 500) begin
      @(posedge clk);
      t++;
    end
    chk(req, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // producer for arc A: writes only if the prediction seen last cycle allowed it
  initial begin
    bit ok;
    forever begin
      @(negedge clk);
      ok = !a_full;
      @(posedge clk);
      #1;
      if (ok && a_en && qa.size() > 0) begin
        a_wr   = 1'b1;
        a_data = qa.pop_front();
      end else a_wr = 1'b0;
    end
  end

  initial begin
    bit ok;
    forever begin
      @(negedge clk);
      ok = !b_full;
      @(posedge clk);
      #1;
      if (ok && b_en && qb.size() > 0) begin
        b_wr   = 1'b1;
        b_data = qb.pop_front();
      end else b_wr = 1'b0;
    end
  end

  // monitor: scoreboard compare plus timing checks
  initial begin
    logic [W-1:0] e;
    forever begin
      @(negedge clk);
      if (!rst && out_wr) begin
        n_out++;
        if (exp_q.size() == 0) chk("R2 unexpected output", 32'(out_data), 32'hffff_ffff);
        else begin
          e = exp_q.pop_front();
          chk("R5 result value/order", 32'(out_data), 32'(e));
        end
        if (prev_out_full) chk("R6 write after stall", 32'd1, 32'd0);
        if (lat_mode) chk("R8 latency", 32'(cyc), 32'(last_wr_cyc + 1));
        if (tp_mode && last_out_cyc >= 0) chk("R7 back-to-back", 32'(cyc), 32'(last_out_cyc + 1));
        last_out_cyc = cyc;
      end
      if (r4_mode && a_wr) begin
        chk("R4 same-cycle full", 32'(a_full), (a_wcnt == DEPTH - 1) ? 32'd1 : 32'd0);
        a_wcnt++;
      end
      if (a_wr && b_wr) last_wr_cyc = cyc;
      prev_out_full = out_full;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_wr in reset", 32'(out_wr), 32'd0);
    chk("R1 a_full in reset", 32'(a_full), 32'd0);
    chk("R1 b_full in reset", 32'(b_full), 32'd0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 out_wr after reset", 32'(out_wr), 32'd0);
    a_en = 1'b1; b_en = 1'b1;

    // R8: single pair into empty arcs
    repeat (3) @(posedge clk);
    lat_mode = 1;
    push_pair(16'h0012, 16'h0034);
    drain("R8 drain");
    lat_mode = 0;

    // R2/R3/R4: arc B starved, arc A fills and reports full
    b_en = 1'b0; r4_mode = 1; a_wcnt = 0;
    base = n_out;
    push_pair(16'h1000, 16'h0001);
    push_pair(16'h2000, 16'h0002);
    push_pair(16'h3000, 16'h0003);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R2 no fire with one arc empty", 32'(n_out - base), 32'd0);
    chk("R3 arc A reports full", 32'(a_full), 32'd1);
    chk("R3 third token held back", 32'(qa.size()), 32'd1);
    r4_mode = 0;
    b_en = 1'b1;
    drain("R3 starved tokens delivered");

    // R6: downstream stall
    @(posedge clk); #1 out_full = 1'b1;
    base = n_out;
    for (int i = 0; i < 4; i++) push_pair(16'(16'h0100 * i + 7), 16'(i * 3));
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R6 no output while stalled", 32'(n_out - base), 32'd0);
    @(posedge clk); #1 out_full = 1'b0;
    drain("R6 resume after stall");

    // R7: sustained stream, one per cycle
    repeat (3) @(posedge clk);
    tp_mode = 1; last_out_cyc = -10;
    base = n_out;
    for (int i = 0; i < 20; i++) push_pair(16'(16'hfff0 + i), 16'(i * 5 + 1));
    drain("R7 stream drained");
    chk("R7 stream count", 32'(n_out - base), 32'd20);
    tp_mode = 0;

    // R5: irregular arrival on B with wraparound values
    for (int i = 0; i < 12; i++) push_pair(16'(16'hff00 + 40 * i), 16'(16'h0123 * i));
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1 b_en = ((i % 3) != 1);
    end
    b_en = 1'b1;
    drain("R5 irregular drained");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule